// File: doc/BRIEF.md
# I2C Serial Memory Target Engine

A clocked I2C target for a 4096-byte serial memory. SCL and SDA are resynchronised into the system clock domain, and START and STOP are found on the synchronised samples. Bytes are shifted in on SCL rising edges and shifted out after SCL falling edges. SDA is driven only through an open-drain enable: while `sda_oe_o` is high, the line is pulled low.

A session opens with a device address byte. After a write header, the engine accepts a two-byte memory address and then data bytes. Each accepted data byte is handed to an external write buffer as a single pulse carrying its address and value. A STOP commits the buffered bytes. After a read header, the engine streams bytes from the current pointer until the master stops acknowledging. While the external write cycle runs (`busy_i`), the engine refuses its device address, so the master can poll until it is accepted again. A write-protect level, sampled once per write session, can reject the whole write.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset `sda_oe_o`, `wbuf_we_o` and `commit_o` are low. Bus activity that does not follow a START (SDA falling while SCL high) is never acknowledged.
- R2: A device address byte is acknowledged only if bits 7:4 equal 4'b1010 and bits 3:1 equal `strap_i`. Bit 0 selects read (1) or write (0). Any other address is NACKed with SDA left released.
- R3: After a write header, the engine acknowledges two address bytes, high byte first. Bits 7:4 of the high byte are ignored, which gives a 12-bit address.
- R4: `sda_oe_o` changes only while the synchronised SCL is low. Read data is presented MSB first.
- R5: Each acknowledged data byte produces one `wbuf_we_o` pulse with `wbuf_addr_o` and `wbuf_data_o`. `wbuf_first_o` is high on the first such byte of a session. A STOP after at least one accepted byte pulses `commit_o`.
- R6: During a multi-byte write the address increments inside its 32-byte page and wraps from the page's last byte to its first.
- R7: While `busy_i` is high, the device address is NACKed.
- R8: `wp_i` is sampled on the SCL falling edge that ends the low-address acknowledge. If it is high, the first data byte is NACKed, no byte reaches the buffer and nothing is committed. A later change of `wp_i` inside the session has no effect.
- R9: After a write, a current-address read returns the byte that follows the last loaded byte within the same page.
- R10: A random read (write header with two address bytes, a repeated START, then a read header) returns the byte at the loaded address.
- R11: A master ACK after a read byte starts the next byte at the next address, wrapping from 4095 to 0. A master NACK ends the transfer.
- R12: A START in the middle of a byte restarts address reception with a cleared bit counter. A START also discards accepted bytes that have not yet been committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pull SDA low when high |
| strap_i | input | 3 | Device address strap bits |
| wp_i | input | 1 | Write-protect level |
| busy_i | input | 1 | External write cycle in progress |
| rd_addr_o | output | 12 | Current read pointer |
| rd_data_i | input | 8 | Memory byte at `rd_addr_o` |
| wbuf_we_o | output | 1 | Accepted data byte strobe |
| wbuf_first_o | output | 1 | First accepted byte of the session |
| wbuf_addr_o | output | 12 | Address of the accepted byte |
| wbuf_data_o | output | 8 | Value of the accepted byte |
| commit_o | output | 1 | Start of the write cycle at STOP |

## Verification
The bench uses the default parameters: a 12-bit address and 32-byte pages. With these values, a handful of bytes is enough to reach the page wrap from offset 28 and the array wrap from 4094. The strap is tied to 3'b101, so changing one strap bit gives a mismatching address. The bench models the write buffer and holds `busy_i` for 400 cycles after each commit, which is long enough for the first poll after a write to be refused.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK} tgt_st_e;
  typedef enum logic [1:0] {K_DEV, K_AHI, K_ALO, K_DATA} byte_kind_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign scl_o      = scl_ff[1];
  assign sda_o      = sda_ff[1];
  assign scl_rise_o = scl_ff[1] & ~scl_q;
  assign scl_fall_o = ~scl_ff[1] & scl_q;
  // SDA edge with SCL high on both samples
  assign start_o    = scl_ff[1] & scl_q & sda_q & ~sda_ff[1];
  assign stop_o     = scl_ff[1] & scl_q & ~sda_q & sda_ff[1];
endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr #(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  input  logic              in_page_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] q, nxt_pg;

  generate
    if (PAGE_W == 0) begin : g_nopage
      assign nxt_pg = q;
    end else begin : g_page
      assign nxt_pg = {q[ADDR_W-1:PAGE_W], PAGE_W'(q[PAGE_W-1:0] + 1'b1)};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (load_i) q <= load_val_i;
    else if (inc_i)  q <= in_page_i ? nxt_pg : q + 1'b1;
  end

  assign ptr_o = q;
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_tgt_pkg::*;
#(
  parameter int         ADDR_W = 12,
  parameter int         PAGE_W = 5,
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        strap_i,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              wbuf_we_o,
  output logic              wbuf_first_o,
  output logic [ADDR_W-1:0] wbuf_addr_o,
  output logic [7:0]        wbuf_data_o,
  output logic              commit_o
);
  localparam int HI_W = ADDR_W - 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_tgt_sync u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  tgt_st_e         st;
  byte_kind_e      kind;
  logic [2:0]      cnt;
  logic            full, ack_q, rw, wp_lat, pend, mack, oe_q;
  logic [7:0]      sh;
  logic [HI_W-1:0] ahi;
  logic            acc, byte_end, p_load, p_inc, p_in_page, dev_slot;
  logic [ADDR_W-1:0] ptr;

  assign byte_end = (st == ST_RX) && scl_fall && full;

  always_comb begin
    unique case (kind)
      K_DEV:   acc = (sh[7:4] == DEV_ID) && (sh[3:1] == strap_i) && !busy_i;
      K_DATA:  acc = !wp_lat;
      default: acc = 1'b1;
    endcase
  end

  assign p_load    = byte_end && (kind == K_ALO);
  assign p_in_page = byte_end && (kind == K_DATA);
  assign p_inc     = (p_in_page && !wp_lat) || ((st == ST_TX) && scl_fall && (cnt == 3'd7));
  assign dev_slot  = (st == ST_RX_ACK) && (kind == K_DEV);

  i2c_tgt_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk_i, .rst_ni,
    .load_i(p_load), .load_val_i({ahi, sh}),
    .inc_i(p_inc), .in_page_i(p_in_page),
    .ptr_o(ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; kind <= K_DEV; cnt <= '0; full <= 1'b0; ack_q <= 1'b0;
      rw <= 1'b0; wp_lat <= 1'b0; pend <= 1'b0; mack <= 1'b0; oe_q <= 1'b0;
      sh <= '0; ahi <= '0;
      wbuf_we_o <= 1'b0; wbuf_first_o <= 1'b0; wbuf_addr_o <= '0;
      wbuf_data_o <= '0; commit_o <= 1'b0;
    end else begin
      wbuf_we_o <= 1'b0;
      commit_o  <= 1'b0;
      if (stop_det) begin
        st <= ST_IDLE; oe_q <= 1'b0;
        commit_o <= pend;
        pend <= 1'b0;
      end else if (start_det) begin
        st <= ST_RX; kind <= K_DEV; cnt <= '0; full <= 1'b0;
        oe_q <= 1'b0; pend <= 1'b0;
      end else begin
        unique case (st)
          ST_RX: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) full <= 1'b1;
            end else if (byte_end) begin
              full <= 1'b0; st <= ST_RX_ACK; ack_q <= acc; oe_q <= acc;
              unique case (kind)
                K_DEV:  rw  <= sh[0];
                K_AHI:  ahi <= sh[HI_W-1:0];
                K_DATA: if (acc) begin
                  wbuf_we_o    <= 1'b1;
                  wbuf_first_o <= !pend;
                  wbuf_addr_o  <= ptr;
                  wbuf_data_o  <= sh;
                  pend         <= 1'b1;
                end
                default: ;
              endcase
            end
          end
          ST_RX_ACK: if (scl_fall) begin
            cnt <= '0;
            if (!ack_q) begin
              st <= ST_IDLE; oe_q <= 1'b0;
            end else if (kind == K_DEV && rw) begin
              st <= ST_TX; sh <= rd_data_i; oe_q <= ~rd_data_i[7];
            end else begin
              st <= ST_RX; oe_q <= 1'b0;
              unique case (kind)
                K_DEV:   kind <= K_AHI;
                K_AHI:   kind <= K_ALO;
                K_ALO:   begin kind <= K_DATA; wp_lat <= wp_i; end
                default: kind <= K_DATA;
              endcase
            end
          end
          ST_TX: if (scl_fall) begin
            if (cnt == 3'd7) begin
              oe_q <= 1'b0; st <= ST_TX_ACK;
            end else begin
              cnt  <= cnt + 3'd1;
              oe_q <= ~sh[6];
              sh   <= {sh[6:0], 1'b0};
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) mack <= ~sda_s;
            else if (scl_fall) begin
              cnt <= '0;
              if (mack) begin
                st <= ST_TX; sh <= rd_data_i; oe_q <= ~rd_data_i[7];
              end else st <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign rd_addr_o = ptr;
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sda_oe_o,
  input logic scl_s,
  input logic stop_det,
  input logic wbuf_we_o,
  input logic commit_o,
  input logic busy_i,
  input logic dev_slot,
  input logic wp_lat
);
  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s); // R4
  AST_COMMIT_ON_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(stop_det)); // R5
  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wbuf_we_o |=> !wbuf_we_o); // R5
  AST_BUSY_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_slot && $rose(sda_oe_o)) |-> !$past(busy_i)); // R7
  AST_WP_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wbuf_we_o |-> !wp_lat); // R8
endmodule

bind i2c_mem_target i2c_mem_target_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sda_oe_o(sda_oe_o), .scl_s(scl_s),
  .stop_det(stop_det), .wbuf_we_o(wbuf_we_o), .commit_o(commit_o),
  .busy_i(busy_i), .dev_slot(dev_slot), .wp_lat(wp_lat)
);

// File: tb/test_i2c_mem_target.sv
module test_i2c_mem_target;
  localparam int Q = 6;
  localparam int BUSY_CYC = 400;
  localparam logic [7:0] DEVW = 8'hAA;
  localparam logic [7:0] DEVR = 8'hAB;
  localparam logic [19:0] VEC [6] = '{20'h000_3C, 20'h5A7_C3, 20'hFFF_01,
                                      20'h01F_80, 20'h800_FF, 20'h123_00};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe, sda_w, busy, we, first, commit;
  logic [11:0] rd_addr, wa;
  logic [7:0]  rd_data, wd;
  logic [2:0]  strap = 3'b101;

  logic [7:0]  mem [4096];
  logic [7:0]  ref_mem [4096];
  logic [11:0] pa [64];
  logic [7:0]  pd [64];
  int pn = 0, busy_cnt = 0, we_cnt = 0, commit_cnt = 0;
  logic [11:0] last_wa = '0;
  logic [7:0]  last_wd = '0;
  logic        last_first = 1'b0;
  logic [7:0]  rbuf [8];
  logic [7:0]  wdat [8];
  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  assign sda_w   = sda_m & ~sda_oe;
  assign busy    = (busy_cnt != 0);
  assign rd_data = mem[rd_addr];

  i2c_mem_target i_i2c_mem_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_w), .sda_oe_o(sda_oe),
    .strap_i(strap), .wp_i(wp), .busy_i(busy), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wbuf_we_o(we), .wbuf_first_o(first), .wbuf_addr_o(wa), .wbuf_data_o(wd),
    .commit_o(commit)
  );

  function automatic logic [7:0] init_val(int a);
    logic [11:0] x = a[11:0];
    return x[7:0] ^ {x[11:8], x[11:8]} ^ 8'h5A;
  endfunction

  // write buffer model
  always @(posedge clk) begin
    if (we) begin
      pa[first ? 0 : pn] <= wa;
      pd[first ? 0 : pn] <= wd;
      pn <= first ? 1 : pn + 1;
      last_wa <= wa; last_wd <= wd; last_first <= first;
      we_cnt <= we_cnt + 1;
    end
    if (commit) begin
      for (int k = 0; k < pn; k++) mem[pa[k]] <= pd[k];
      commit_cnt <= commit_cnt + 1;
      busy_cnt <= BUSY_CYC;
    end else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw(); qw();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); ack = ~sda_w; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl_m = 1'b1; qw(); b[i] = sda_w; qw(); scl_m = 1'b0; qw();
    end
    sda_m = ~mack; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw(); sda_m = 1'b1;
  endtask

  // header plus n data bytes; returns number of ACKs seen
  task automatic do_write(input logic [11:0] a, input int n, output int acks);
    logic ak;
    acks = 0;
    bus_start();
    send_byte(DEVW, ak); acks += int'(ak);
    send_byte({4'h9, a[11:8]}, ak); acks += int'(ak);
    send_byte(a[7:0], ak); acks += int'(ak);
    for (int i = 0; i < n; i++) begin
      send_byte(wdat[i], ak); acks += int'(ak);
      if (ak) ref_mem[{a[11:5], 5'(a[4:0] + i)}] = wdat[i];
    end
    bus_stop();
  endtask

  task automatic wait_ready(output int tries);
    logic ak;
    tries = 0;
    do begin
      bus_start(); send_byte(DEVW, ak); bus_stop(); tries++;
    end while (!ak && tries < 50);
  endtask

  task automatic rd_seq(input logic [11:0] a, input int n);
    logic ak;
    bus_start();
    send_byte(DEVW, ak); send_byte({4'h0, a[11:8]}, ak); send_byte(a[7:0], ak);
    bus_start();
    send_byte(DEVR, ak);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int acks, tries, wc, cc;
    logic ak;
    for (int i = 0; i < 4096; i++) begin
      mem[i] = init_val(i); ref_mem[i] = init_val(i);
    end
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 reset oe", sda_oe, 0);
    chk("R1 reset we", we, 0);
    chk("R1 reset commit", commit, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 valid address clocked without START
    scl_m = 1'b0; qw();
    send_byte(DEVW, ak);
    chk("R1 no start nack", ak, 0);
    bus_stop();

    // R5/R3/R10 table walk: byte write, poll, random read
    for (int v = 0; v < 6; v++) begin
      cc = commit_cnt;
      wdat[0] = VEC[v][7:0];
      do_write(VEC[v][19:8], 1, acks);
      chk("R3 write acks", acks, 4);
      chk("R5 buffer addr", last_wa, VEC[v][19:8]);
      chk("R5 buffer data", last_wd, VEC[v][7:0]);
      chk("R5 first flag", last_first, 1);
      chk("R5 commit", commit_cnt, cc + 1);
      wait_ready(tries);
      if (v == 0) chk("R7 poll refused while busy", tries > 1, 1);
      rd_seq(VEC[v][19:8], 1);
      chk("R10 random read", rbuf[0], ref_mem[VEC[v][19:8]]);
    end

    // R2 strap and id mismatch
    bus_start(); send_byte(8'hA8, ak); bus_stop();
    chk("R2 strap mismatch nack", ak, 0);
    bus_start(); send_byte(8'hBA, ak); bus_stop();
    chk("R2 id mismatch nack", ak, 0);

    // R6 page wrap from offset 28
    for (int i = 0; i < 6; i++) wdat[i] = 8'hD0 + 8'(i);
    do_write(12'h03C, 6, acks);
    chk("R6 page acks", acks, 9);
    chk("R6 last buffer addr", last_wa, 12'h021);
    wait_ready(tries);
    // R9 current-address read
    bus_start(); send_byte(DEVR, ak); recv_byte(1'b0, rbuf[0]); bus_stop();
    chk("R9 current read", rbuf[0], ref_mem[12'h022]);
    rd_seq(12'h020, 2);
    chk("R6 wrapped byte0", rbuf[0], 8'hD4);
    chk("R6 wrapped byte1", rbuf[1], 8'hD5);
    rd_seq(12'h03E, 2);
    chk("R6 page tail", {rbuf[0], rbuf[1]}, 16'hD2D3);

    // R11 sequential read across array end
    rd_seq(12'hFFE, 3);
    chk("R11 seq 0xFFE", rbuf[0], ref_mem[12'hFFE]);
    chk("R11 seq 0xFFF", rbuf[1], ref_mem[12'hFFF]);
    chk("R11 seq wrap 0", rbuf[2], ref_mem[12'h000]);

    // R8 write protect rejects
    wc = we_cnt; cc = commit_cnt;
    wp = 1'b1; wdat[0] = 8'h77;
    do_write(12'h100, 1, acks);
    wp = 1'b0;
    chk("R8 data nacked", acks, 3);
    chk("R8 no buffer write", we_cnt, wc);
    chk("R8 no commit", commit_cnt, cc);
    wait_ready(tries);
    chk("R8 no write cycle", tries, 1);
    rd_seq(12'h100, 1);
    chk("R8 data unchanged", rbuf[0], ref_mem[12'h100]);
    // R8 late wp change ignored
    bus_start();
    send_byte(DEVW, ak); send_byte(8'h01, ak); send_byte(8'h40, ak);
    send_byte(8'h11, ak);
    wp = 1'b1;
    send_byte(8'h22, ak);
    chk("R8 late wp ignored", ak, 1);
    bus_stop(); wp = 1'b0;
    ref_mem[12'h140] = 8'h11; ref_mem[12'h141] = 8'h22;
    wait_ready(tries);
    rd_seq(12'h140, 2);
    chk("R8 late wp data", {rbuf[0], rbuf[1]}, 16'h1122);

    // R12 repeated START discards uncommitted byte
    cc = commit_cnt;
    bus_start();
    send_byte(DEVW, ak); send_byte(8'h02, ak); send_byte(8'h00, ak); send_byte(8'h99, ak);
    bus_start(); send_byte(DEVW, ak); bus_stop();
    chk("R12 discarded commit", commit_cnt, cc);
    // R12 START mid-byte resets bit counter
    bus_start(); send_bits(8'hF0, 5);
    scl_m = 1'b0; qw();
    bus_start(); send_byte(DEVW, ak); bus_stop();
    chk("R12 address after abort", ak, 1);
    rd_seq(12'h200, 1);
    chk("R12 data untouched", rbuf[0], ref_mem[12'h200]);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule